// File: doc/BRIEF.md
# Accumulator Processor with Increment-and-Skip

A small processor core with one accumulator. It fetches fixed-width instruction words from a single memory that holds both code and data, and it runs them strictly one after another. Each word is split into an operation code and an operand field. The operand field is either a memory address or a small immediate constant. The second operand of every arithmetic operation is the accumulator itself.

The core drives a synchronous single-port memory. Read data returns one clock after the address. A sequencer steps each instruction through fetch, decode and, when the instruction needs it, a data read and a write-back. The instruction set covers:

- loads, both immediate and from memory;
- a store;
- an add, with an immediate or a memory operand;
- an increment-and-skip-if-zero on a memory word;
- a branch taken on a zero accumulator;
- an unconditional jump;
- a halt.

When the core halts it freezes in place and raises a halt output until reset. Typical use is a self-contained control loop or test sequencer. Software counts iterations with a negative counter kept in memory and leaves the loop with the skip instruction.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word holds the operation code in bits [9:6] and the operand field in bits [5:0]. The codes are: 0 halt, 1 load immediate, 2 load direct, 3 store, 4 add immediate, 5 add direct, 6 increment-and-skip-if-zero, 7 branch-if-zero, 8 jump.
- R2: Load immediate puts the zero-extended field into the accumulator. Load direct puts the memory word at the field address into the accumulator. Both set the zero flag when the new accumulator value is zero and clear it otherwise.
- R3: Add immediate adds the zero-extended field to the accumulator without a data read. Add direct adds the memory word at the field address. Sums wrap modulo 1024, and the zero flag follows the result.
- R4: Store writes the accumulator to the field address. It leaves the accumulator and the zero flag unchanged.
- R5: Increment-and-skip reads the addressed word, adds one modulo 1024 and writes the result back. When the result is zero, the next instruction is skipped (the PC advances by two). The instruction never changes the accumulator or the zero flag.
- R6: Branch-if-zero loads the PC from the field only when the zero flag is set, and otherwise falls through. Jump always loads the PC from the field.
- R7: Counted from the fetch, load immediate, add immediate, store, branch, jump and halt take 2 cycles. Load direct and add direct take 3. Increment-and-skip takes 4.
- R8: The core fetches each instruction at the address held in the PC, and it expects memory read data exactly one cycle after it presents an address.
- R9: Halt and every undefined code (9 to 15) stop the core. The halt output goes high and stays high until reset. The memory address holds the address of the halting instruction, and no write occurs.
- R10: Reset is asynchronous. It clears the PC and the accumulator, sets the zero flag, drives the halt output low and starts a fetch at address 0.
- R11: The PC wraps from 63 to 0 when it advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 6 | Memory address for fetch, read or write |
| mem_wdata_o | output | 10 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 10 | Memory read data, valid one cycle after the address |
| halt_o | output | 1 | High once the core has stopped |

## Verification
The bench builds the core with its default 4-bit operation code and 6-bit operand field. This gives a 10-bit word and a 64-word memory that the bench can fill completely on every run. Because the memory is that small, code can be placed at the last two addresses to show the PC wrapping. Because the word is 10 bits, a loop that doubles a value ten times carries it through 1024 and back to zero. A counter preset to -10 modulo 1024 reaches zero through the skip instruction after exactly ten passes. Each table entry is checked both for its stored result and for the exact number of cycles it takes to reach halt. Together these checks pin down the per-instruction cycle cost and the skip and branch paths.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_READ,
    ST_WB,
    ST_HALT
  } state_e;

  localparam logic [3:0] OP_HALT = 4'd0;
  localparam logic [3:0] OP_LDI  = 4'd1;
  localparam logic [3:0] OP_LDA  = 4'd2;
  localparam logic [3:0] OP_STA  = 4'd3;
  localparam logic [3:0] OP_ADDI = 4'd4;
  localparam logic [3:0] OP_ADD  = 4'd5;
  localparam logic [3:0] OP_ISZ  = 4'd6;
  localparam logic [3:0] OP_BZ   = 4'd7;
  localparam logic [3:0] OP_JMP  = 4'd8;

  typedef struct packed {
    logic pc_inc;
    logic pc_load;
    logic acc_ld;
    logic acc_add;
    logic opnd_mem;
    logic tmp_ld;
    logic addr_field;
    logic we;
    logic wdata_tmp;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int unsigned WORD_W = 10
) (
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] opnd_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] inc_src_i,
  output logic [WORD_W-1:0] res_o,
  output logic [WORD_W-1:0] inc_o
);

  // sums wrap at 2^WORD_W by truncation
  always_comb begin
    res_o = add_i ? (acc_i + opnd_i) : opnd_i;
    inc_o = inc_src_i + WORD_W'(1);
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int unsigned OPC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             zero_i,
  input  logic             tmp_zero_i,
  output logic             decode_o,
  output ctrl_t            ctrl_o,
  output logic             halt_o
);

  state_e state_q, state_d;
  ctrl_t  c;

  always_comb begin
    c       = '0;
    state_d = state_q;
    case (state_q)
      ST_FETCH: state_d = ST_DECODE;
      ST_DECODE: begin
        state_d = ST_FETCH;
        case (opcode_i)
          OP_LDI:  begin c.acc_ld = 1'b1; c.pc_inc = 1'b1; end
          OP_ADDI: begin c.acc_ld = 1'b1; c.acc_add = 1'b1; c.pc_inc = 1'b1; end
          OP_STA:  begin c.addr_field = 1'b1; c.we = 1'b1; c.pc_inc = 1'b1; end
          OP_LDA, OP_ADD, OP_ISZ: begin
            c.addr_field = 1'b1;
            c.pc_inc     = 1'b1;
            state_d      = ST_READ;
          end
          OP_BZ: begin
            c.pc_load = zero_i;
            c.pc_inc  = !zero_i;
          end
          OP_JMP:  c.pc_load = 1'b1;
          default: state_d = ST_HALT;  // halt and undefined codes
        endcase
      end
      ST_READ: begin
        state_d = ST_FETCH;
        case (opcode_i)
          OP_LDA: begin c.acc_ld = 1'b1; c.opnd_mem = 1'b1; end
          OP_ADD: begin c.acc_ld = 1'b1; c.acc_add = 1'b1; c.opnd_mem = 1'b1; end
          OP_ISZ: begin c.tmp_ld = 1'b1; state_d = ST_WB; end
          default: ;
        endcase
      end
      ST_WB: begin
        c.addr_field = 1'b1;
        c.we         = 1'b1;
        c.wdata_tmp  = 1'b1;
        c.pc_inc     = tmp_zero_i;  // skip the next instruction
        state_d      = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign decode_o = (state_q == ST_DECODE);
  assign ctrl_o   = c;
  assign halt_o   = (state_q == ST_HALT);

  // R9
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  // R9
  halt_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !ctrl_o.we);

  // R4
  write_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.we |-> (state_q == ST_DECODE || state_q == ST_WB));

  // R7
  read_after_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ) |-> ($past(state_q) == ST_DECODE));

  // R7
  wb_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) |-> ($past(state_q) == ST_READ));

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int unsigned OPC_W  = 4,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned WORD_W = OPC_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              decode_i,
  input  ctrl_t             ctrl_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [OPC_W-1:0]  opcode_o,
  output logic              zero_o,
  output logic              tmp_zero_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              mem_we_o
);

  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q, acc_q, tmp_q;
  logic              zero_q;
  logic [WORD_W-1:0] instr, opnd, res, inc;
  logic [ADDR_W-1:0] field;

  // decode straight off the read data, later cycles use the latched word
  assign instr    = decode_i ? mem_rdata_i : ir_q;
  assign field    = instr[ADDR_W-1:0];
  assign opcode_o = instr[WORD_W-1 -: OPC_W];
  assign opnd     = ctrl_i.opnd_mem ? mem_rdata_i : WORD_W'(field);

  acc_cpu_alu #(.WORD_W(WORD_W)) u_alu (
    .acc_i    (acc_q),
    .opnd_i   (opnd),
    .add_i    (ctrl_i.acc_add),
    .inc_src_i(mem_rdata_i),
    .res_o    (res),
    .inc_o    (inc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      ir_q   <= '0;
      acc_q  <= '0;
      tmp_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      if (decode_i) ir_q <= mem_rdata_i;
      if (ctrl_i.pc_load)     pc_q <= field;
      else if (ctrl_i.pc_inc) pc_q <= pc_q + ADDR_W'(1);
      if (ctrl_i.acc_ld) begin
        acc_q  <= res;
        zero_q <= (res == '0);
      end
      if (ctrl_i.tmp_ld) tmp_q <= inc;
    end
  end

  assign zero_o      = zero_q;
  assign tmp_zero_o  = (tmp_q == '0);
  assign mem_addr_o  = ctrl_i.addr_field ? field : pc_q;
  assign mem_wdata_o = ctrl_i.wdata_tmp ? tmp_q : acc_q;
  assign mem_we_o    = ctrl_i.we;

  // R2
  zero_tracks_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_q == (acc_q == '0));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned OPC_W  = 4,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned WORD_W = OPC_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              halt_o
);

  ctrl_t            ctrl;
  logic             decode, zero, tmp_zero;
  logic [OPC_W-1:0] opcode;

  acc_cpu_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .opcode_i  (opcode),
    .zero_i    (zero),
    .tmp_zero_i(tmp_zero),
    .decode_o  (decode),
    .ctrl_o    (ctrl),
    .halt_o    (halt_o)
  );

  acc_cpu_dp #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .decode_i   (decode),
    .ctrl_i     (ctrl),
    .mem_rdata_i(mem_rdata_i),
    .opcode_o   (opcode),
    .zero_o     (zero),
    .tmp_zero_o (tmp_zero),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_we_o   (mem_we_o)
  );

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] mem_addr;
  logic [9:0] mem_wdata, mem_rdata;
  logic       mem_we, halt;

  logic [9:0] mem [64];
  logic [9:0] img [64];
  logic       tb_we = 1'b0;
  logic [5:0] tb_addr = '0;
  logic [9:0] tb_wdata = '0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  acc_cpu uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mem_addr_o (mem_addr),
    .mem_wdata_o(mem_wdata),
    .mem_we_o   (mem_we),
    .mem_rdata_i(mem_rdata),
    .halt_o     (halt)
  );

  always_ff @(posedge clk) begin
    if (tb_we)       mem[tb_addr] <= tb_wdata;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // word = {code[3:0], field[5:0]}; result at 50, data at 60
  typedef struct packed {
    logic [0:5][9:0] prog;
    logic [9:0]      data;
    logic [9:0]      exp;
    logic [7:0]      cyc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{'{10'h045, 10'h107, 10'h0F2, 10'h000, 10'h000, 10'h000}, 10'd0,    10'd12,  8'd8},
    '{'{10'h0BC, 10'h17C, 10'h0F2, 10'h000, 10'h000, 10'h000}, 10'd100,  10'd200, 8'd10},
    '{'{10'h0BC, 10'h11E, 10'h0F2, 10'h000, 10'h000, 10'h000}, 10'd1000, 10'd6,   8'd9},
    '{'{10'h045, 10'h1BC, 10'h049, 10'h0F2, 10'h000, 10'h000}, 10'd1023, 10'd5,   8'd10},
    '{'{10'h045, 10'h1BC, 10'h049, 10'h0F2, 10'h000, 10'h000}, 10'd7,    10'd9,   8'd12},
    '{'{10'h040, 10'h1C3, 10'h049, 10'h102, 10'h0F2, 10'h000}, 10'd0,    10'd2,   8'd10},
    '{'{10'h041, 10'h1C3, 10'h049, 10'h102, 10'h0F2, 10'h000}, 10'd0,    10'd11,  8'd12},
    '{'{10'h043, 10'h203, 10'h049, 10'h0F2, 10'h000, 10'h000}, 10'd0,    10'd3,   8'd8},
    '{'{10'h040, 10'h1BC, 10'h1C4, 10'h049, 10'h103, 10'h0F2}, 10'd5,    10'd3,   8'd14},
    '{'{10'h046, 10'h0F2, 10'h3FF, 10'h101, 10'h0F2, 10'h000}, 10'd0,    10'd6,   8'd6},
    '{'{10'h0BC, 10'h1C3, 10'h049, 10'h101, 10'h0F2, 10'h000}, 10'd0,    10'd1,   8'd11}
  };

  function automatic string vtag(int v);
    case (v)
      0:       return "R1 R3 load/add immediate";
      1:       return "R2 R3 load/add direct";
      2:       return "R3 wrap";
      3:       return "R5 skip taken";
      4:       return "R5 no skip";
      5:       return "R6 branch taken";
      6:       return "R6 branch not taken";
      7:       return "R6 jump";
      8:       return "R4 R5 flag kept";
      9:       return "R9 undefined code";
      default: return "R2 zero from load";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int a = 0; a < 64; a++) img[a] = '0;
  endtask

  // load image under reset, release, count cycles to halt
  task automatic run(output int cyc);
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < 64; a++) begin
      tb_we = 1'b1; tb_addr = 6'(a); tb_wdata = img[a];
      @(negedge clk);
    end
    tb_we = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halt && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    bit frozen;

    // R10 reset state
    @(negedge clk);
    @(negedge clk);
    chk("R10 halt in reset", int'(halt), 0);
    chk("R10 we in reset", int'(mem_we), 0);
    chk("R8 R10 fetch address in reset", int'(mem_addr), 0);

    for (int v = 0; v < NV; v++) begin
      clear_img();
      for (int k = 0; k < 6; k++) img[k] = VECS[v].prog[k];
      img[60] = VECS[v].data;
      run(cyc);
      chk(vtag(v), int'(mem[50]), int'(VECS[v].exp));
      chk({"R7 cycles ", vtag(v)}, cyc, int'(VECS[v].cyc));
      if (v == 3) chk("R5 incremented word wraps to zero", int'(mem[60]), 0);
      if (v == 9) chk("R9 address held at halting word", int'(mem_addr), 2);
    end

    // R10 R11: zero flag set by reset takes the branch, PC wraps 63 -> 0
    clear_img();
    img[0]  = 10'h1FE;
    img[62] = 10'h045;
    img[63] = 10'h0F2;
    run(cyc);
    chk("R11 wrap result", int'(mem[50]), 5);
    chk("R10 R11 wrap cycles", cyc, 10);

    // R5: doubling loop, counter -5 -> 32
    clear_img();
    img[0] = 10'h0BC; img[1] = 10'h17C; img[2] = 10'h0FC;
    img[3] = 10'h1BD; img[4] = 10'h200;
    img[60] = 10'd1; img[61] = 10'd1019;
    run(cyc);
    chk("R5 five doublings", int'(mem[60]), 32);
    chk("R7 five doublings cycles", cyc, 70);

    // R5: ten doublings, 1024 mod 2^10
    img[61] = 10'd1014;
    run(cyc);
    chk("R3 R5 ten doublings", int'(mem[60]), 0);
    chk("R5 counter reaches zero", int'(mem[61]), 0);
    chk("R7 ten doublings cycles", cyc, 140);

    // R9 frozen after halt
    frozen = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!halt || mem_we || mem_addr != 6'd5) frozen = 1'b0;
    end
    chk("R9 frozen after halt", int'(frozen), 1);

    // R10 asynchronous reset out of halt
    #2;
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears halt", int'(halt), 0);
    chk("R10 reset returns to address 0", int'(mem_addr), 0);

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b1;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 mid-run reset write", int'(mem_we), 0);
    chk("R10 mid-run reset address", int'(mem_addr), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule